// File: doc/BRIEF.md
# SPI Paged Register-File Slave

This block is the serial front end of a register file that is split into pages. An external SPI master selects the slave by pulling chip select low and then clocks 16-bit words in mode 1 (SCLK idles low, the master and the slave both change data on the rising edge, and both sample on the falling edge). The first complete word of every selection is a command. It gives the transfer direction, a page number and a start register. Any number of data words follow the command. Each data word goes to or comes from the current register, and the pointer then steps to the next register.

The pointer steps only inside the addressed page. After the last register of a page it returns to register 0 of that same page, for both reads and writes. Two pages exist. Every other page code is reserved: writes to a reserved page are dropped and reads from one return zero. The serial pins are brought into the fast system clock through synchronisers, and the edges of SCLK are detected in that clock domain. SCLK must therefore run well below the system clock, with each SCLK half period at least six system clocks. The register storage sits outside the block and is reached through a plain parallel port: one page/address bus, a one-cycle write strobe, and a read strobe with a combinational read-data return.

Top module: `pgspi_slave`

## Requirements
- R1: MOSI is sampled on the falling SCLK edge and MISO changes only after a rising SCLK edge. Words are 16 bits long and travel MSB first.
- R2: The first complete word after chip select falls is decoded as a command. Bit 15 gives the direction (1 = read, 0 = write), bits 14:11 give the page, bits 10:6 give the start register, and bits 5:0 have no effect.
- R3: Each complete data word of a write transaction produces exactly one `reg_we` pulse, one system clock long. The pulse carries the latched page, the current pointer and the received word.
- R4: In a read transaction, the word at the start register appears on MISO with its MSB on the first rising SCLK edge after the command. Each later word follows on the next 16 SCLK cycles.
- R5: After every data word the pointer increases by one. From register 31 it wraps to register 0 of the same page, for reads and for writes.
- R6: For page codes 2 to 15, `reg_we` is never asserted and every data word read returns 0x0000.
- R7: If chip select rises in the middle of a word, that word is never written. The next selection again begins with a command.
- R8: MISO is 0 whenever chip select is high. MISO is also 0 while the command word is shifted and throughout a write transaction.
- R9: After reset, MISO is 0 and `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Chip select, active low |
| miso | output | 1 | Serial data to the master |
| reg_page | output | 4 | Page of the current register access |
| reg_addr | output | 5 | Register pointer within the page |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Data for the write strobe |
| reg_re | output | 1 | Read strobe; `reg_rdata` is sampled in the same cycle |
| reg_rdata | input | 16 | Read data from the register file, combinational on page/address |

## Verification
A falling SCLK edge reaches the block's logic three system clocks after the pin changes: two synchroniser stages plus one edge register. A write strobe follows one clock after that detection. The bench therefore compares register-file contents only after chip select has been high for several SCLK periods. A read word is loaded one clock after the detected falling edge that ends the previous word, and its MSB appears on MISO three clocks after the next rising edge. The bench samples MISO at the end of each SCLK high phase, eight system clocks after the rising edge, the same point at which a master samples. The MISO-idle rule and the reserved-page write rule are compared on every system clock, on the falling clock edge.

// File: rtl/pgspi_pkg.sv
// Shared widths, command field positions and types for the paged SPI slave.
package pgspi_pkg;
    localparam int WORD_W   = 16;
    localparam int PAGE_W   = 4;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = $clog2(WORD_W);
    localparam int DIR_BIT  = 15;
    localparam int PAGE_LSB = 11;
    localparam int ADDR_LSB = 6;

    typedef struct packed {
        logic              rd;
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;

    // Extract direction, page and start address; low bits are ignored.
    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.rd   = w[DIR_BIT];
        c.page = w[PAGE_LSB +: PAGE_W];
        c.addr = w[ADDR_LSB +: ADDR_W];
        return c;
    endfunction
endpackage

// File: rtl/pgspi_sync.sv
// Brings sclk, mosi and cs_n into the system clock domain and flags SCLK edges.
// Assumes each SCLK half period lasts several system clocks.
module pgspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic sel
);
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] mosi_q;
    logic [STAGES-1:0] csn_q;
    logic              sclk_d;

    // Synchroniser chains plus one delay stage for SCLK edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            mosi_q <= '0;
            csn_q  <= '1;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
            csn_q  <= {csn_q[STAGES-2:0], cs_n};
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
    assign mosi_s    = mosi_q[STAGES-1];
    assign sel       = ~csn_q[STAGES-1];
endmodule

// File: rtl/pgspi_shifter.sv
// Serial shift engine: samples MOSI on falling edges and counts bits to
// flag complete words. Shifts its transmit word onto MISO on rising edges.
// Everything clears while the slave is deselected.
module pgspi_shifter
    import pgspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic              word_done,
    output logic [WORD_W-1:0] word,
    output logic              miso_q
);
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] tx_sr;

    // Receive, count and transmit bits; a deselect drops any partial word.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
        end else begin
            if (sclk_fall) begin
                rx_sr   <= {rx_sr[WORD_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_rise) begin
                miso_q <= tx_sr[WORD_W-1];
                tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
            end
            if (load) begin
                tx_sr <= load_data;
            end
        end
    end

    assign word_done = sel && sclk_fall && (bit_cnt == CNT_W'(WORD_W-1));
    assign word      = {rx_sr[WORD_W-2:0], mosi_s};
endmodule

// File: rtl/pgspi_ctrl.sv
// Transaction control: decodes the command word, keeps the page and the
// pointer (wrapping inside the page), and issues register-file strobes.
// Assumes reg_rdata is combinational on reg_page/reg_addr.
module pgspi_ctrl
    import pgspi_pkg::*;
#(
    parameter int NUM_PAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic [PAGE_W-1:0] reg_page,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_re,
    output logic              load,
    output logic [WORD_W-1:0] load_data
);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    phase_e            phase;
    logic              dir_rd;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] ptr;
    logic              wr_pend;
    logic              ld_pend;
    logic [WORD_W-1:0] wdata_q;
    logic              page_ok;
    cmd_t              cmd;

    assign cmd     = decode_cmd(word);
    assign page_ok = (32'(page_q) < NUM_PAGES);

    // Phase tracking, command latch, pointer stepping and strobe scheduling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CMD;
            dir_rd  <= 1'b0;
            page_q  <= '0;
            ptr     <= '0;
            wr_pend <= 1'b0;
            ld_pend <= 1'b0;
            wdata_q <= '0;
        end else begin
            wr_pend <= 1'b0;
            ld_pend <= 1'b0;
            if (wr_pend) begin
                ptr <= ptr + PTR_ONE;
            end
            if (!sel) begin
                phase <= PH_CMD;
            end else if (word_done) begin
                if (phase == PH_CMD) begin
                    dir_rd  <= cmd.rd;
                    page_q  <= cmd.page;
                    ptr     <= cmd.addr;
                    ld_pend <= cmd.rd;
                    phase   <= PH_DATA;
                end else if (dir_rd) begin
                    ptr     <= ptr + PTR_ONE;
                    ld_pend <= 1'b1;
                end else begin
                    wr_pend <= 1'b1;
                    wdata_q <= word;
                end
            end
        end
    end

    assign reg_page  = page_q;
    assign reg_addr  = ptr;
    assign reg_we    = wr_pend & page_ok;
    assign reg_wdata = wdata_q;
    assign reg_re    = ld_pend & page_ok;
    assign load      = ld_pend;
    assign load_data = page_ok ? reg_rdata : '0;
endmodule

// File: rtl/pgspi_slave.sv
// Top level of the paged register-file SPI slave (mode 1, 16-bit words).
// Assumes SCLK runs well below clk; MISO is forced low while deselected.
module pgspi_slave
    import pgspi_pkg::*;
#(
    parameter int NUM_PAGES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    output logic [PAGE_W-1:0] reg_page,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_re,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              mosi_s;
    logic              sel;
    logic              load;
    logic [WORD_W-1:0] load_data;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic              miso_q;

    pgspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s), .sel(sel)
    );

    pgspi_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .mosi_s(mosi_s), .load(load), .load_data(load_data),
        .word_done(word_done), .word(word), .miso_q(miso_q)
    );

    pgspi_ctrl #(.NUM_PAGES(NUM_PAGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .word_done(word_done), .word(word),
        .reg_rdata(reg_rdata), .reg_page(reg_page), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
        .load(load), .load_data(load_data)
    );

    // Pin-level gate so MISO is low as soon as chip select rises.
    assign miso = cs_n ? 1'b0 : miso_q;
endmodule

// File: rtl/pgspi_slave_chk.sv
// Protocol checker for pgspi_slave, attached through bind.
module pgspi_slave_chk
    import pgspi_pkg::*;
#(
    parameter int NUM_PAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso,
    input logic [PAGE_W-1:0] reg_page,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we
);
    AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !miso); // R8
    AST_NO_RESERVED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (32'(reg_page) < NUM_PAGES)); // R6
    AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R3
    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1))); // R5
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_page)); // R2
endmodule

bind pgspi_slave pgspi_slave_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
    .reg_page(reg_page), .reg_addr(reg_addr), .reg_we(reg_we)
);

// File: tb/pgspi_slave_bench.sv
// Bench: behavioural SPI master, behavioural register file and a shadow model.
module pgspi_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic        miso;
    logic [3:0]  reg_page;
    logic [4:0]  reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic        reg_re;
    logic [15:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] rf     [2][32];
    logic [15:0] shadow [2][32];
    logic [15:0] tx_buf [8];
    logic [15:0] rx_buf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgspi_slave u_pgspi_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .reg_page(reg_page), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] init_val(input int p, input int a);
        return 16'(p * 16'h1000 + 16'h0100 + a);
    endfunction

    // Behavioural register file behind the parallel port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < 32; a++)
                    rf[p][a] <= init_val(p, a);
        end else if (reg_we && reg_page < 4'd2) begin
            rf[reg_page[0]][reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = (reg_page < 4'd2) ? rf[reg_page[0]][reg_addr] : 16'hDEAD;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparisons: idle MISO (R8) and no reserved-page write (R6).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cs_n) chk("R8 miso idle", {15'd0, miso}, 16'd0);
            if (reg_we) chk("R6 write page", {15'd0, reg_page >= 4'd2}, 16'd0);
        end
    end

    // One word (or its first nbits) in mode 1, MSB first; returns sampled MISO.
    task automatic spi_word(input logic [15:0] w, input int nbits, output logic [15:0] r);
        r = '0;
        for (int i = 15; i > 15 - nbits; i--) begin
            @(negedge clk);
            sclk = 1'b1;
            mosi = w[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    // Full transaction plus model update and read-data comparison.
    task automatic txn(input logic [15:0] cmd, input int nwords, input int partial);
        logic [15:0] r;
        int pg;
        int p;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_word(cmd, 16, r);
        chk("R8 miso during command", r, 16'h0000);
        for (int k = 0; k < nwords; k++) spi_word(tx_buf[k], 16, rx_buf[k]);
        if (partial > 0) spi_word(tx_buf[nwords], partial, r);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4 * HALF) @(negedge clk);
        pg = int'(cmd[14:11]);
        p  = int'(cmd[10:6]);
        for (int k = 0; k < nwords; k++) begin
            if (cmd[15]) begin
                chk("R1 R4 R5 R6 read word", rx_buf[k], (pg < 2) ? shadow[pg][p] : 16'h0000);
            end else begin
                chk("R8 miso during write", rx_buf[k], 16'h0000);
                if (pg < 2) shadow[pg][p] = tx_buf[k];
            end
            p = (p + 1) % 32;
        end
    endtask

    task automatic check_mem(input string req);
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 32; a++)
                chk(req, rf[p][a], shadow[p][a]);
    endtask

    initial begin
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 32; a++)
                shadow[p][a] = init_val(p, a);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset miso", {15'd0, miso}, 16'd0);
        chk("R9 reset we", {15'd0, reg_we}, 16'd0);

        // R3 R5: write page 1 from register 30, wrapping to 0 and 1.
        tx_buf[0] = 16'hC0DE; tx_buf[1] = 16'hBEEF; tx_buf[2] = 16'h1357; tx_buf[3] = 16'h2468;
        txn(16'h0F80, 4, 0);
        check_mem("R3 R5 wrap write");

        // R3: write page 1 from register 0 (command 0x0800).
        tx_buf[0] = 16'h5A5A; tx_buf[1] = 16'hA5A5;
        txn(16'h0800, 2, 0);
        check_mem("R3 page1 write");

        // R4: read page 0 from register 0 (command 0x8000).
        txn(16'h8000, 3, 0);
        // R4 R5: read page 1 from register 30, wrapping.
        txn(16'h8F80, 4, 0);

        // R6: reserved-page write dropped, reserved-page read returns zero.
        tx_buf[0] = 16'hFFFF; tx_buf[1] = 16'h0F0F;
        txn(16'h1800, 2, 0);
        check_mem("R6 reserved write");
        txn(16'hA800, 2, 0);

        // R7: word cut short by deselect is not written.
        tx_buf[0] = 16'h9876; tx_buf[1] = 16'h4321;
        txn(16'h0100, 1, 8);
        check_mem("R7 partial word");
        // R7: next selection starts with a command; reads back register 4 and 5.
        txn(16'h8100, 2, 0);

        // R2: low command bits have no effect.
        txn(16'h803F, 2, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule